// File: doc/BRIEF.md
# Dual-Channel Serial DAC Update Sequencer

This block feeds an external two-channel serial DAC. Firmware writes two 16-bit output codes, two 16-bit command fields and a control word through a simple write port. The block then waits for a periodic update strobe from a timing generator. On each accepted strobe it shifts two 32-bit words out on a frame-sync, serial-clock and serial-data trio: first the word for channel 0, then the word for channel 1. After the second word it pulses one or both active-low load lines, which move the new codes to the analog outputs together.

Each word carries its command field in the upper half and the code in the lower half. Codes go out exactly as written, whether they are offset binary for a voltage range or straight binary for a current range. The serial clock comes from a programmable divider on the system clock. A full update takes 136 half periods of the serial clock. With the divider at 1 and a 50 MHz system clock that is 5.44 µs, which fits inside a 6 µs update period. If a strobe arrives while an update is still running, that strobe is dropped and a sticky overrun flag is set.

Top module: `dacseq_top`

## Requirements
- R1: An update starts only when the selected update strobe is high at a clock edge while `busy` is low. A register write never starts a transfer. `busy` rises on the edge that accepts the strobe and falls 136·H cycles later. H = hdiv+1 system clocks, where hdiv is the divider value latched at the accepting edge.
- R2: After reset and whenever the block is idle, the outputs are `dac_sync_n`=1, `dac_sclk`=0, `dac_sdo`=0, `dac_ldac_n`=2'b11, `busy`=0 and `overrun`=0. All registers reset to zero.
- R3: Each word is 32 bits, sent MSB first. Bits 31..16 are the channel's command register and bits 15..0 are its code, unmodified. `dac_sdo` changes only on the rising step of `dac_sclk` and is stable across the falling step. `dac_sdo` returns to 0 when sync rises.
- R4: Let step s be the accepting edge plus s·H cycles. Sync is low for steps 0..64 and 66..130. The clock rises on steps 1,3,…,63 (frame 0) and 67,…,129 (frame 1). It falls on the steps in between. It is low outside those windows.
- R5: Channel 0's word is always sent first and channel 1's word second, within the same update.
- R6: The load lines are low for steps 132..135, according to ld_mode (ctrl bits 3:2). Mode 0 drives both lines low. Mode 1 drives only `dac_ldac_n[0]` low. Mode 2 drives only `dac_ldac_n[1]` low. Mode 3 drives neither.
- R7: The code source is ctrl bit 0. With 0, the codes come from registers at addresses 0 (ch0) and 1 (ch1). With 1, they come from `din0`/`din1`, sampled at the accepting edge. The command fields are at addresses 2 (ch0) and 3 (ch1).
- R8: The update-timing source is ctrl bit 1. With 0, `upd_strobe[0]` starts updates. With 1, `upd_strobe[1]` starts updates. The other strobe has no effect.
- R9: A selected strobe seen while `busy` is high is ignored and sets `overrun` from the next cycle on. The flag holds until a write to address 5 clears it. A set in the same cycle wins over the clear.
- R10: The control register is at address 4. Bits 11:4 hold hdiv, which gives a half period of hdiv+1 system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| upd_strobe | input | 2 | Update strobes from the timing generator |
| din0 | input | 16 | Streamed code for channel 0 |
| din1 | input | 16 | Streamed code for channel 1 |
| dac_sync_n | output | 1 | Active-low frame sync |
| dac_sclk | output | 1 | Serial clock |
| dac_sdo | output | 1 | Serial data, MSB first |
| dac_ldac_n | output | 2 | Active-low load strobes |
| busy | output | 1 | Update in progress |
| overrun | output | 1 | Sticky dropped-strobe flag |

## Verification
The bench covers three divider settings, including hdiv=0. At hdiv=0 the serial clock toggles every cycle, which exposes off-by-one errors in the half-period counter as shifted edges. A strobe pulse lands mid-transfer, and another strobe is held for two cycles. A design that restarts on these, or fails to latch the overrun flag, drops frames or corrupts sync. Every load mode is used, and the non-selected strobe is pulsed while idle. A design with the wrong lane or wrong strobe shows a mismatch on `dac_ldac_n` or a spurious `busy`. Streamed codes are changed after the accepting edge, which catches a design that samples `din` late.

// File: rtl/dacseq_pkg.sv
package dacseq_pkg;
  localparam int DIV_W   = 8;
  localparam int CODE_W  = 16;
  localparam int WORD_W  = 2 * CODE_W;
  localparam int ADDR_W  = 3;
  localparam int LOAD_HP = 4;

  localparam logic [ADDR_W-1:0] A_CODE0 = 3'd0;
  localparam logic [ADDR_W-1:0] A_CODE1 = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMD0  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CMD1  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd4;
  localparam logic [ADDR_W-1:0] A_OVCLR = 3'd5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_SHIFT, ST_TAIL, ST_GAP, ST_LOAD
  } seq_state_e;

  typedef struct packed {
    logic [DIV_W-1:0] hdiv;
    logic [1:0]       ld_mode;
    logic             tsel;
    logic             src;
  } seq_ctrl_t;

  localparam int CTRL_W = $bits(seq_ctrl_t);
endpackage

// File: rtl/dacseq_regs.sv
module dacseq_regs
  import dacseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CODE_W-1:0] wr_data,
  input  logic              ovr_set,
  output logic [CODE_W-1:0] code0,
  output logic [CODE_W-1:0] code1,
  output logic [CODE_W-1:0] cmd0,
  output logic [CODE_W-1:0] cmd1,
  output seq_ctrl_t         ctrl,
  output logic              overrun
);
  logic ovr_d;

  always_comb begin
    ovr_d = overrun;
    if (wr_en && wr_addr == A_OVCLR) ovr_d = 1'b0;
    if (ovr_set)                     ovr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code0   <= '0;
      code1   <= '0;
      cmd0    <= '0;
      cmd1    <= '0;
      ctrl    <= '0;
      overrun <= 1'b0;
    end else begin
      overrun <= ovr_d;
      if (wr_en) begin
        case (wr_addr)
          A_CODE0: code0 <= wr_data;
          A_CODE1: code1 <= wr_data;
          A_CMD0:  cmd0  <= wr_data;
          A_CMD1:  cmd1  <= wr_data;
          A_CTRL:  ctrl  <= seq_ctrl_t'(wr_data[CTRL_W-1:0]);
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dacseq_tick.sv
module dacseq_tick #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          run,
  input  logic [DW-1:0] hdiv,
  output logic          step
);
  logic [DW-1:0] cnt_q, cnt_d, hdiv_q, hdiv_d;

  always_comb begin
    cnt_d  = cnt_q;
    hdiv_d = hdiv_q;
    if (start) begin
      hdiv_d = hdiv;
      cnt_d  = hdiv;
    end else if (run) begin
      if (cnt_q == '0) cnt_d = hdiv_q;
      else             cnt_d = cnt_q - 1'b1;
    end
  end

  assign step = run && !start && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hdiv_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      hdiv_q <= hdiv_d;
    end
  end
endmodule

// File: rtl/dacseq_fsm.sv
module dacseq_fsm
  import dacseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              step,
  input  logic [WORD_W-1:0] word0,
  input  logic [WORD_W-1:0] word1,
  input  logic [1:0]        ld_mode,
  output logic              sync_n,
  output logic              sclk,
  output logic              sdo,
  output logic [1:0]        ldac_n,
  output logic              busy
);
  localparam int BC_W = $clog2(WORD_W);
  localparam int LC_W = $clog2(LOAD_HP);

  seq_state_e        st_q, st_d;
  logic [WORD_W-1:0] sh_q, sh_d, hold_q, hold_d;
  logic [BC_W-1:0]   bc_q, bc_d;
  logic [LC_W-1:0]   lc_q, lc_d;
  logic [1:0]        mode_q, mode_d, ld_q, ld_d;
  logic              ch_q, ch_d, sy_q, sy_d, ck_q, ck_d, do_q, do_d;

  always_comb begin
    st_d = st_q; sh_d = sh_q; hold_d = hold_q; bc_d = bc_q; lc_d = lc_q;
    mode_d = mode_q; ld_d = ld_q; ch_d = ch_q; sy_d = sy_q; ck_d = ck_q; do_d = do_q;
    case (st_q)
      ST_IDLE: if (start) begin
        st_d = ST_LEAD; sy_d = 1'b0; ch_d = 1'b0;
        sh_d = word0; hold_d = word1; mode_d = ld_mode;
        bc_d = BC_W'(WORD_W - 1);
      end
      ST_LEAD: if (step) begin
        st_d = ST_SHIFT; ck_d = 1'b1; do_d = sh_q[WORD_W-1];
      end
      ST_SHIFT: if (step) begin
        if (ck_q) begin
          ck_d = 1'b0;
          sh_d = {sh_q[WORD_W-2:0], 1'b0};
          if (bc_q == '0) st_d = ST_TAIL;
          else            bc_d = bc_q - 1'b1;
        end else begin
          ck_d = 1'b1; do_d = sh_q[WORD_W-1];
        end
      end
      ST_TAIL: if (step) begin
        st_d = ST_GAP; sy_d = 1'b1; do_d = 1'b0;
      end
      ST_GAP: if (step) begin
        if (!ch_q) begin
          st_d = ST_LEAD; ch_d = 1'b1; sy_d = 1'b0;
          sh_d = hold_q; bc_d = BC_W'(WORD_W - 1);
        end else begin
          st_d = ST_LOAD; lc_d = LC_W'(LOAD_HP - 1);
          ld_d = {~(mode_q == 2'd0 || mode_q == 2'd2),
                  ~(mode_q == 2'd0 || mode_q == 2'd1)};
        end
      end
      ST_LOAD: if (step) begin
        if (lc_q == '0) begin
          st_d = ST_IDLE; ld_d = 2'b11;
        end else begin
          lc_d = lc_q - 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; sh_q <= '0; hold_q <= '0; bc_q <= '0; lc_q <= '0;
      mode_q <= '0; ld_q <= 2'b11; ch_q <= 1'b0; sy_q <= 1'b1; ck_q <= 1'b0; do_q <= 1'b0;
    end else begin
      st_q <= st_d; sh_q <= sh_d; hold_q <= hold_d; bc_q <= bc_d; lc_q <= lc_d;
      mode_q <= mode_d; ld_q <= ld_d; ch_q <= ch_d; sy_q <= sy_d; ck_q <= ck_d; do_q <= do_d;
    end
  end

  assign sync_n = sy_q;
  assign sclk   = ck_q;
  assign sdo    = do_q;
  assign ldac_n = ld_q;
  assign busy   = (st_q != ST_IDLE);
endmodule

// File: rtl/dacseq_top.sv
module dacseq_top
  import dacseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CODE_W-1:0] wr_data,
  input  logic [1:0]        upd_strobe,
  input  logic [CODE_W-1:0] din0,
  input  logic [CODE_W-1:0] din1,
  output logic              dac_sync_n,
  output logic              dac_sclk,
  output logic              dac_sdo,
  output logic [1:0]        dac_ldac_n,
  output logic              busy,
  output logic              overrun
);
  logic [1:0]        rst_sq;
  logic              rst_i, strobe_sel, accept, step;
  logic [CODE_W-1:0] code0, code1, cmd0, cmd1;
  seq_ctrl_t         ctrl;
  logic [WORD_W-1:0] word0, word1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sq <= 2'b00;
    else        rst_sq <= {rst_sq[0], 1'b1};
  end
  assign rst_i = rst_sq[1];

  assign strobe_sel = ctrl.tsel ? upd_strobe[1] : upd_strobe[0];
  assign accept     = strobe_sel && !busy;
  assign word0      = {cmd0, ctrl.src ? din0 : code0};
  assign word1      = {cmd1, ctrl.src ? din1 : code1};

  dacseq_regs u_regs (
    .clk(clk), .rst_n(rst_i), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ovr_set(strobe_sel && busy), .code0(code0), .code1(code1), .cmd0(cmd0),
    .cmd1(cmd1), .ctrl(ctrl), .overrun(overrun)
  );

  dacseq_tick #(.DW(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_i), .start(accept), .run(busy), .hdiv(ctrl.hdiv), .step(step)
  );

  dacseq_fsm u_fsm (
    .clk(clk), .rst_n(rst_i), .start(accept), .step(step), .word0(word0), .word1(word1),
    .ld_mode(ctrl.ld_mode), .sync_n(dac_sync_n), .sclk(dac_sclk), .sdo(dac_sdo),
    .ldac_n(dac_ldac_n), .busy(busy)
  );
endmodule

// File: rtl/dacseq_chk.sv
module dacseq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [2:0] wr_addr,
  input logic [1:0] upd_strobe,
  input logic       dac_sync_n,
  input logic       dac_sclk,
  input logic       dac_sdo,
  input logic [1:0] dac_ldac_n,
  input logic       busy,
  input logic       overrun
);
  // R4: the clock only runs inside a frame
  a_r4_sclk_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    dac_sclk |-> !dac_sync_n);
  // R6: the load pulse never overlaps a frame
  a_r6_ldac_outside_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_ldac_n != 2'b11) |-> dac_sync_n);
  // R2: quiet outputs while idle
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (dac_sync_n && !dac_sclk && !dac_sdo && dac_ldac_n == 2'b11));
  // R1: a transfer begins only after a strobe
  a_r1_start_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(|upd_strobe));
  // R3: data held across the falling clock step
  a_r3_sdo_stable_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dac_sclk) |-> $stable(dac_sdo));
  // R9: overrun stays set until cleared
  a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !(wr_en && wr_addr == 3'd5)) |=> overrun);
endmodule

bind dacseq_top dacseq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .upd_strobe(upd_strobe),
  .dac_sync_n(dac_sync_n), .dac_sclk(dac_sclk), .dac_sdo(dac_sdo),
  .dac_ldac_n(dac_ldac_n), .busy(busy), .overrun(overrun)
);

// File: tb/dacseq_top_tb_top.sv
module dacseq_top_tb_top;
  logic        clk, rst_n, wr_en;
  logic [2:0]  wr_addr;
  logic [15:0] wr_data, din0, din1;
  logic [1:0]  upd_strobe;
  logic        dac_sync_n, dac_sclk, dac_sdo, busy, overrun;
  logic [1:0]  dac_ldac_n;

  int checks = 0, fails = 0, cyc = 0;
  bit chk_en = 0;

  dacseq_top dut_i (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // ---------------- reference model ----------------
  logic [15:0] m_code0, m_code1, m_cmd0, m_cmd1;
  logic [11:0] m_ctrl;
  logic [31:0] m_w0, m_w1;
  logic [1:0]  m_mode;
  bit          m_busy, m_ovr;
  int          m_t, m_h;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_code0 = 0; m_code1 = 0; m_cmd0 = 0; m_cmd1 = 0; m_ctrl = 0;
      m_busy = 0; m_ovr = 0; m_t = 0; m_h = 1;
    end else begin
      bit sel, set_now;
      sel = m_ctrl[1] ? upd_strobe[1] : upd_strobe[0];
      set_now = m_busy && sel;
      if (m_busy) begin
        m_t++;
        if (m_t == 136 * m_h) m_busy = 0;
      end else if (sel) begin
        m_busy = 1; m_t = 0; m_h = int'(m_ctrl[11:4]) + 1; m_mode = m_ctrl[3:2];
        m_w0 = {m_cmd0, m_ctrl[0] ? din0 : m_code0};
        m_w1 = {m_cmd1, m_ctrl[0] ? din1 : m_code1};
      end
      if (wr_en) begin
        case (wr_addr)
          3'd0: m_code0 = wr_data;
          3'd1: m_code1 = wr_data;
          3'd2: m_cmd0 = wr_data;
          3'd3: m_cmd1 = wr_data;
          3'd4: m_ctrl = wr_data[11:0];
          3'd5: m_ovr = 0;
          default: ;
        endcase
      end
      if (set_now) m_ovr = 1;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    cyc++;
    if (chk_en) begin
      int s, rel;
      logic e_sync, e_sclk, e_sdo;
      logic [1:0] e_ld;
      logic [31:0] w;
      e_sync = 1; e_sclk = 0; e_sdo = 0; e_ld = 2'b11; rel = 0; w = 0;
      if (m_busy) begin
        s = m_t / m_h;
        e_sync = !((s < 65) || (s >= 66 && s < 131));
        if (s >= 1 && s <= 64) begin rel = s; w = m_w0; end
        else if (s >= 67 && s <= 130) begin rel = s - 66; w = m_w1; end
        if (rel > 0) begin
          e_sclk = rel[0];
          e_sdo  = w[31 - (rel - 1) / 2];
        end
        if (s >= 132 && s <= 135)
          e_ld = {!(m_mode == 0 || m_mode == 2), !(m_mode == 0 || m_mode == 1)};
      end
      chk("R4", "sync_n", int'(dac_sync_n), int'(e_sync));
      chk("R4", "sclk", int'(dac_sclk), int'(e_sclk));
      chk("R3", "sdo", int'(dac_sdo), int'(e_sdo));
      chk("R6", "ldac_n", int'(dac_ldac_n), int'(e_ld));
      chk("R1", "busy", int'(busy), int'(m_busy));
      chk("R9", "overrun", int'(overrun), int'(m_ovr));
    end
  end

  // DAC-side word capture: sample on falling clock, word ends on sync rise
  logic [31:0] cap;
  logic        p_sclk = 0, p_sync = 1;
  logic [31:0] got[$];
  always @(negedge clk) begin
    if (p_sclk && !dac_sclk) cap = {cap[30:0], dac_sdo};
    if (!p_sync && dac_sync_n) got.push_back(cap);
    p_sclk = dac_sclk; p_sync = dac_sync_n;
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic pulse(input int idx, input int len);
    @(negedge clk); upd_strobe[idx] = 1'b1;
    repeat (len) @(negedge clk);
    upd_strobe[idx] = 1'b0;
  endtask

  task automatic expect_words(input string req, input logic [31:0] e0, input logic [31:0] e1);
    chk(req, "frame count", got.size(), 2);
    if (got.size() >= 2) begin
      chk(req, "ch0 word", int'(got[0]), int'(e0));
      chk(req, "ch1 word", int'(got[1]), int'(e1));
    end
    got.delete();
  endtask

  initial begin
    rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = 0; upd_strobe = 0; din0 = 0; din1 = 0;
    repeat (3) @(negedge clk);
    // R2: reset state
    chk("R2", "reset sync_n", int'(dac_sync_n), 1);
    chk("R2", "reset ldac_n", int'(dac_ldac_n), 3);
    chk("R2", "reset busy", int'(busy), 0);
    chk("R2", "reset overrun", int'(overrun), 0);
    rst_n = 1;
    @(negedge clk); chk_en = 1;
    repeat (4) @(negedge clk);

    // R1/R10: writes alone do not start; hdiv=1, src=regs, tsel=0, mode 0
    wr(3'd0, 16'hFDF0); wr(3'd1, 16'h0149);
    wr(3'd2, 16'h0030); wr(3'd3, 16'h0031);
    wr(3'd4, 16'h0010);
    repeat (5) @(negedge clk);
    chk("R1", "no start on write", int'(busy), 0);
    pulse(0, 1);
    repeat (300) @(negedge clk);
    expect_words("R5", {16'h0030, 16'hFDF0}, {16'h0031, 16'h0149});

    // R8: non-selected strobe has no effect
    pulse(1, 1);
    repeat (10) @(negedge clk);
    chk("R8", "other strobe ignored", int'(busy), 0);
    chk("R8", "no frames", got.size(), 0);

    // R8/R6/R9: tsel=1, mode 1, hdiv=0, strobe mid-transfer
    wr(3'd4, 16'h0006);
    wr(3'd0, 16'h8000); wr(3'd1, 16'h7FFF);
    pulse(1, 1);
    repeat (40) @(negedge clk);
    pulse(1, 1);
    repeat (150) @(negedge clk);
    expect_words("R9", {16'h0030, 16'h8000}, {16'h0031, 16'h7FFF});
    chk("R9", "overrun set", int'(overrun), 1);
    wr(3'd5, 16'h0000);
    @(negedge clk);
    chk("R9", "overrun cleared", int'(overrun), 0);

    // R7: streamed codes, mode 2, hdiv=2; din changes after accept
    wr(3'd4, 16'h0029);
    din0 = 16'hFFFF; din1 = 16'h0000;
    pulse(0, 1);
    din0 = 16'h1111; din1 = 16'h2222;
    repeat (430) @(negedge clk);
    expect_words("R7", {16'h0030, 16'hFFFF}, {16'h0031, 16'h0000});

    // R6/R9: mode 3, strobe held two cycles, hdiv=0, src regs
    wr(3'd4, 16'h000C);
    pulse(0, 2);
    repeat (150) @(negedge clk);
    expect_words("R3", {16'h0030, 16'h8000}, {16'h0031, 16'h7FFF});
    chk("R9", "held strobe overrun", int'(overrun), 1);
    chk("R2", "idle after run", int'(busy), 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule